// File: doc/BRIEF.md
# CAN Transceiver Mode and Fail-Safe Controller

This block is the digital state keeper of a high-speed CAN transceiver. It chooses between an active state and a low-power idle state and drives three enables. The driver enable, the receiver enable and the mid-supply bias enable go to analog circuitry that is not part of this block. The controller also reports the chosen state and whether a thermal cut is active.

The state is chosen by an active-low enable pin. The pin is synchronized into the clock domain, and a floating pin is taken as high, which selects idle. Two digitized supply under-voltage flags, one for the core supply and one for the I/O supply, can override the pin. Each flag must stay high for a full blanking interval before it forces idle, so shorter glitches have no effect. When the flag clears, the pin choice applies again.

A junction-temperature code from a sensor is compared against a shutdown point. A lower release point gives hysteresis. An over-temperature condition removes only the driver enable, and the receive path stays up.

Top module: `can_xcvr_mode_ctrl`

## Requirements
- R1: While reset is high, and in the first cycles after it falls, the block is in idle (mode_o = 0) with all enables low. With the pin held low, active mode is reached only at the third rising edge after reset falls.
- R2: enable_n_i low requests active mode and high requests idle. A change on the pin appears on mode_o at the third rising edge after the change, through a two-stage synchronizer and the mode register.
- R3: In active mode (mode_o = 1) rx_en_o and bias_en_o are 1, and drv_en_o is 1 unless the thermal cut is set.
- R4: In idle (mode_o = 0) drv_en_o, rx_en_o and bias_en_o are all 0.
- R5: uv_flags_i bit 0 is the core-supply flag and bit 1 is the I/O-supply flag. A flag that is high at BLANK_CYC consecutive rising edges forces idle from the next edge on. A flag that is high at fewer consecutive edges leaves the mode unchanged.
- R6: Once the forcing flag is sampled low, the mode returns to what the pin selects at the following edge, whatever the pin did during the event.
- R7: Under-voltage forcing also acts in idle: a pin request for active mode is ignored while a blanked flag is still high.
- R8: tsd_o rises at the edge that samples temp_code_i >= SHUT_CODE. While tsd_o is 1, drv_en_o is 0 and rx_en_o and bias_en_o are unaffected.
- R9: tsd_o falls only at an edge that samples temp_code_i <= SHUT_CODE - HYST_CODE. Codes between the two thresholds hold its value.
- R10: The thermal comparison runs in idle as well, so a cut set in idle keeps the driver off after a move to active mode until the code has cooled.
- R11: With both supply flags low, mode_o reaches the state the pin requests within MODE_CYC cycles of the last pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_n_i | input | 1 | Active-low mode select pin (asynchronous) |
| uv_flags_i | input | NUM_SUP | Digitized under-voltage flags, bit 0 core, bit 1 I/O |
| temp_code_i | input | TEMP_W | Junction temperature code, 1 LSB = 1 degree |
| drv_en_o | output | 1 | Bus driver enable |
| rx_en_o | output | 1 | Receiver enable |
| bias_en_o | output | 1 | Mid-supply bus bias enable |
| mode_o | output | 1 | Mode status: 0 idle, 1 active |
| tsd_o | output | 1 | Thermal cut active |

## Verification
The bound checker checks the following on every cycle:
- the enable pattern that each mode allows;
- the driver staying off under a thermal cut;
- idle being forced once a flag has been high for the full blanking count;
- both sides of the temperature hysteresis;
- a limit on how long the mode may disagree with the pin.

Other behaviours can only be shown by the bench scenarios. These are the exact edge on which a pin change or a flag recovery lands, glitches one cycle shorter than the blanking count having no effect, the return to a pin level changed during an event, and a thermal cut carried over from idle into active mode. The bench sweeps every glitch length around the blanking count for each flag alone and for both together. It also walks the temperature code up and down across both thresholds.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

    typedef enum logic {
        MODE_IDLE   = 1'b0,
        MODE_ACTIVE = 1'b1
    } xcvr_mode_e;

    typedef struct packed {
        logic drv;
        logic rx;
        logic bias;
    } xcvr_enables_t;

    // pin level after synchronization: 1 requests idle
    function automatic xcvr_mode_e mode_select(input logic pin_n_sync,
                                               input logic uv_forced);
        if (uv_forced || pin_n_sync)
            return MODE_IDLE;
        return MODE_ACTIVE;
    endfunction

    function automatic xcvr_enables_t enables_for(input xcvr_mode_e mode,
                                                  input logic thermal_cut);
        xcvr_enables_t e;
        e.rx   = (mode == MODE_ACTIVE);
        e.bias = (mode == MODE_ACTIVE);
        e.drv  = (mode == MODE_ACTIVE) && !thermal_cut;
        return e;
    endfunction

    function automatic logic hyst_next(input logic cur,
                                       input logic at_or_above_trip,
                                       input logic at_or_below_release);
        if (at_or_above_trip)
            return 1'b1;
        if (at_or_below_release)
            return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/xcvr_sync2.sv
module xcvr_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/xcvr_uv_blank.sv
module xcvr_uv_blank #(
    parameter int BLANK_CYC = 750
) (
    input  logic clk,
    input  logic rst,
    input  logic uv_i,
    output logic forced_o
);
    localparam int CW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);
    localparam logic [CW-1:0] LAST = CW'(BLANK_CYC - 1);

    logic [CW-1:0] run_q;
    logic          forced_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= '0;
            forced_q <= 1'b0;
        end else if (!uv_i) begin
            run_q    <= '0;
            forced_q <= 1'b0;
        end else if (run_q == LAST) begin
            forced_q <= 1'b1;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign forced_o = forced_q;
endmodule

// File: rtl/xcvr_thermal.sv
module xcvr_thermal
    import xcvr_mode_pkg::*;
#(
    parameter int TEMP_W    = 8,
    parameter int SHUT_CODE = 175,
    parameter int HYST_CODE = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              cut_o
);
    localparam logic [TEMP_W-1:0] TRIP = TEMP_W'(SHUT_CODE);
    localparam logic [TEMP_W-1:0] REL  = TEMP_W'(SHUT_CODE - HYST_CODE);

    logic cut_q;
    logic hot;
    logic cool;

    always_comb begin
        hot  = (temp_i >= TRIP);
        cool = (temp_i <= REL);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cut_q <= 1'b0;
        else
            cut_q <= hyst_next(cut_q, hot, cool);
    end

    assign cut_o = cut_q;
endmodule

// File: rtl/can_xcvr_mode_ctrl.sv
module can_xcvr_mode_ctrl
    import xcvr_mode_pkg::*;
#(
    parameter int NUM_SUP   = 2,
    parameter int BLANK_CYC = 750,
    parameter int MODE_CYC  = 500,
    parameter int TEMP_W    = 8,
    parameter int SHUT_CODE = 175,
    parameter int HYST_CODE = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable_n_i,
    input  logic [NUM_SUP-1:0] uv_flags_i,
    input  logic [TEMP_W-1:0]  temp_code_i,
    output logic               drv_en_o,
    output logic               rx_en_o,
    output logic               bias_en_o,
    output logic               mode_o,
    output logic               tsd_o
);
    logic               pin_n_sync;
    logic [NUM_SUP-1:0] sup_forced;
    logic               uv_forced;
    logic               cut;
    xcvr_mode_e         mode_q;
    xcvr_enables_t      en;

    xcvr_sync2 #(.RST_VAL(1'b1)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d_i (enable_n_i),
        .q_o (pin_n_sync)
    );

    for (genvar s = 0; s < NUM_SUP; s++) begin : g_sup
        xcvr_uv_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
            .clk      (clk),
            .rst      (rst),
            .uv_i     (uv_flags_i[s]),
            .forced_o (sup_forced[s])
        );
    end

    assign uv_forced = |sup_forced;

    xcvr_thermal #(
        .TEMP_W   (TEMP_W),
        .SHUT_CODE(SHUT_CODE),
        .HYST_CODE(HYST_CODE)
    ) u_thermal (
        .clk    (clk),
        .rst    (rst),
        .temp_i (temp_code_i),
        .cut_o  (cut)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_IDLE;
        else
            mode_q <= mode_select(pin_n_sync, uv_forced);
    end

    always_comb en = enables_for(mode_q, cut);

    assign drv_en_o  = en.drv;
    assign rx_en_o   = en.rx;
    assign bias_en_o = en.bias;
    assign mode_o    = (mode_q == MODE_ACTIVE);
    assign tsd_o     = cut;
endmodule

// File: rtl/xcvr_mode_checker.sv
module xcvr_mode_checker #(
    parameter int NUM_SUP   = 2,
    parameter int BLANK_CYC = 750,
    parameter int MODE_CYC  = 500,
    parameter int TEMP_W    = 8,
    parameter int SHUT_CODE = 175,
    parameter int HYST_CODE = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               enable_n_i,
    input logic [NUM_SUP-1:0] uv_flags_i,
    input logic [TEMP_W-1:0]  temp_code_i,
    input logic               drv_en_o,
    input logic               rx_en_o,
    input logic               bias_en_o,
    input logic               mode_o,
    input logic               tsd_o
);
    localparam int UW = $clog2(BLANK_CYC + 1);
    localparam int LW = $clog2(MODE_CYC + 1);

    logic [UW-1:0] ucnt_q [NUM_SUP];
    logic          uv_long;
    logic [LW-1:0] lag_q;
    logic          pin_prev_q;

    for (genvar s = 0; s < NUM_SUP; s++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst || !uv_flags_i[s])
                ucnt_q[s] <= '0;
            else if (ucnt_q[s] < UW'(BLANK_CYC))
                ucnt_q[s] <= ucnt_q[s] + 1'b1;
        end
    end

    always_comb begin
        uv_long = 1'b0;
        for (int s = 0; s < NUM_SUP; s++)
            if (ucnt_q[s] >= UW'(BLANK_CYC) && uv_flags_i[s])
                uv_long = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lag_q      <= '0;
            pin_prev_q <= 1'b1;
        end else begin
            pin_prev_q <= enable_n_i;
            if ((|uv_flags_i) || (enable_n_i != pin_prev_q) || (mode_o != enable_n_i))
                lag_q <= '0;
            else if (lag_q < LW'(MODE_CYC))
                lag_q <= lag_q + 1'b1;
        end
    end

    // R4
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !mode_o |-> (!drv_en_o && !rx_en_o && !bias_en_o));

    // R3
    a_r3_active_rx_bias: assert property (@(posedge clk) disable iff (rst)
        mode_o |-> (rx_en_o && bias_en_o && (drv_en_o == !tsd_o)));

    // R8
    a_r8_cut_drv_off: assert property (@(posedge clk) disable iff (rst)
        tsd_o |-> !drv_en_o);

    // R5
    a_r5_uv_forces_idle: assert property (@(posedge clk) disable iff (rst)
        uv_long |=> !mode_o);

    // R9
    a_r9_hold_cut: assert property (@(posedge clk) disable iff (rst)
        (tsd_o && (int'(temp_code_i) > SHUT_CODE - HYST_CODE)) |=> tsd_o);

    // R9
    a_r9_hold_clear: assert property (@(posedge clk) disable iff (rst)
        (!tsd_o && (int'(temp_code_i) < SHUT_CODE)) |=> !tsd_o);

    // R8
    a_r8_trip: assert property (@(posedge clk) disable iff (rst)
        (int'(temp_code_i) >= SHUT_CODE) |=> tsd_o);

    // R11
    a_r11_mode_latency: assert property (@(posedge clk) disable iff (rst)
        lag_q < LW'(MODE_CYC));
endmodule

bind can_xcvr_mode_ctrl xcvr_mode_checker #(
    .NUM_SUP  (NUM_SUP),
    .BLANK_CYC(BLANK_CYC),
    .MODE_CYC (MODE_CYC),
    .TEMP_W   (TEMP_W),
    .SHUT_CODE(SHUT_CODE),
    .HYST_CODE(HYST_CODE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable_n_i (enable_n_i),
    .uv_flags_i (uv_flags_i),
    .temp_code_i(temp_code_i),
    .drv_en_o   (drv_en_o),
    .rx_en_o    (rx_en_o),
    .bias_en_o  (bias_en_o),
    .mode_o     (mode_o),
    .tsd_o      (tsd_o)
);

// File: tb/tb_can_xcvr_mode_ctrl.sv
module tb_can_xcvr_mode_ctrl;
    localparam int NUM_SUP = 2;
    localparam int BLANK   = 5;
    localparam int MCYC    = 8;
    localparam int TW      = 8;
    localparam int SHUT    = 175;
    localparam int HYST    = 10;

    logic clk = 1'b0;
    logic rst;
    logic enable_n;
    logic [NUM_SUP-1:0] uv;
    logic [TW-1:0] temp;
    logic drv_en, rx_en, bias_en, mode, tsd;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    can_xcvr_mode_ctrl #(
        .NUM_SUP(NUM_SUP), .BLANK_CYC(BLANK), .MODE_CYC(MCYC),
        .TEMP_W(TW), .SHUT_CODE(SHUT), .HYST_CODE(HYST)
    ) dut (
        .clk(clk), .rst(rst), .enable_n_i(enable_n), .uv_flags_i(uv),
        .temp_code_i(temp), .drv_en_o(drv_en), .rx_en_o(rx_en),
        .bias_en_o(bias_en), .mode_o(mode), .tsd_o(tsd)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic exp_mode,
                       input logic exp_drv, input logic exp_tsd);
        logic [4:0] act, exp;
        act = {mode, drv_en, rx_en, bias_en, tsd};
        exp = {exp_mode, exp_drv, exp_mode, exp_mode, exp_tsd};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t {mode,drv,rx,bias,tsd} actual=%b expected=%b",
                     req, $time, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; enable_n = 1'b1; uv = '0; temp = TW'(25);
        repeat (3) tick();
        chk("R1 reset idle", 1'b0, 1'b0, 1'b0);

        // R1: pin low during reset, active only at third edge after release
        enable_n = 1'b0;
        tick();
        chk("R1 still in reset", 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            tick();
            chk("R1 power-up", (k >= 3), (k >= 3), 1'b0);
        end

        // R2 / R4: pin high -> idle at third edge
        enable_n = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            tick();
            chk("R2 R4 pin high", (k < 3), (k < 3), 1'b0);
        end
        // R2 / R3: pin low -> active at third edge
        enable_n = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            tick();
            chk("R2 R3 pin low", (k >= 3), (k >= 3), 1'b0);
        end

        // R5 / R6: glitch-length sweep on each flag and both together
        for (int m = 1; m <= 3; m++) begin
            for (int h = 1; h <= BLANK + 2; h++) begin
                logic e;
                uv = NUM_SUP'(m);
                for (int k = 1; k <= h + 3; k++) begin
                    tick();
                    if (k == h) uv = '0;
                    e = !((k - 1 >= BLANK) && (k - 1 <= h));
                    chk((h < BLANK) ? "R5 short glitch ignored" : "R5 R6 blanked force",
                        e, e, 1'b0);
                end
                repeat (2) tick();
            end
        end

        // R6: pin changed during the event, recovery follows new pin level
        uv = 2'b01;
        repeat (BLANK + 2) tick();
        chk("R5 forced idle", 1'b0, 1'b0, 1'b0);
        enable_n = 1'b1;
        repeat (4) tick();
        uv = '0;
        for (int k = 1; k <= 3; k++) begin
            tick();
            chk("R6 recover to pin idle", 1'b0, 1'b0, 1'b0);
        end
        enable_n = 1'b0;
        repeat (3) tick();
        chk("R6 pin active after recovery", 1'b1, 1'b1, 1'b0);

        // R7: forcing while in idle blocks an active request
        enable_n = 1'b1;
        repeat (4) tick();
        uv = 2'b10;
        repeat (BLANK + 1) tick();
        enable_n = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            tick();
            chk("R7 forced in idle", 1'b0, 1'b0, 1'b0);
        end
        uv = '0;
        tick();
        chk("R7 release edge", 1'b0, 1'b0, 1'b0);
        tick();
        chk("R6 R7 back active", 1'b1, 1'b1, 1'b0);

        // R8 / R9: rising and falling temperature sweep in active mode
        for (int t = 160; t <= 185; t++) begin
            logic c;
            temp = TW'(t);
            tick();
            c = (t >= SHUT);
            chk("R8 rising temperature", 1'b1, !c, c);
        end
        for (int t = 185; t >= 155; t--) begin
            logic c;
            temp = TW'(t);
            tick();
            c = (t > SHUT - HYST);
            chk("R9 falling temperature", 1'b1, !c, c);
        end

        // R10: cut set in idle carries into active mode
        enable_n = 1'b1;
        repeat (4) tick();
        temp = TW'(200);
        tick();
        chk("R10 cut in idle", 1'b0, 1'b0, 1'b1);
        enable_n = 1'b0;
        repeat (3) tick();
        chk("R10 active with cut", 1'b1, 1'b0, 1'b1);
        temp = TW'(170);
        tick();
        chk("R9 R10 mid band holds", 1'b1, 1'b0, 1'b1);
        temp = TW'(165);
        tick();
        chk("R9 R10 cooled", 1'b1, 1'b1, 1'b0);

        // R11: pin change settles quickly with flags low
        enable_n = 1'b1;
        repeat (MCYC - 1) tick();
        chk("R11 settle idle", 1'b0, 1'b0, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule